// File: doc/BRIEF.md
# Interval Timer with Interrupt Gating

This block pairs a 16-bit up-counter with the interrupt control logic of a small 8-bit controller. Software talks to it through a byte-wide register bus with four locations. Two of them hold the low and high bytes of the reload value, one holds the timer run bit and count source, and one holds the interrupt bits. The counter runs either on every system clock or on rising edges of an external pin, which passes through a two-flop synchronizer first. When the counter passes its all-ones value, it reloads from the preload value and sets a pending flag.

The interrupt request output is asserted only when three things are true at once: the pending flag is set, the timer source enable is set, and the global master enable is set.

The master enable is a three-state machine: GATE_SHUT, GATE_OPEN and GATE_SERVICE. The output master enable is high only in GATE_OPEN. The transitions are:
- Reset enters GATE_SHUT.
- The CPU "interrupt entered" strobe moves GATE_OPEN to GATE_SERVICE. In GATE_SHUT or GATE_SERVICE the strobe leaves the state unchanged.
- The "return from interrupt" strobe moves GATE_SERVICE or GATE_SHUT to GATE_OPEN.
- A software write of 1 to the master enable bit moves GATE_SERVICE or GATE_SHUT to GATE_OPEN.
- A software write of 0 to the master enable bit moves GATE_OPEN to GATE_SHUT.

When strobes and a write land in the same cycle, the entry strobe has priority over the return strobe, and the return strobe has priority over the software write.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, all four registers read 0, the counter is 0, the master enable is off and `irq_req` is 0.
- R2: With run bit (address 2, bit 0) set and mode bit (address 2, bit 1) at 0, the counter adds one on every clock.
- R3: With the run bit clear, the counter holds its value.
- R4: With mode bit 1 and run set, the counter adds one per rising edge of `ext_evt`, taken after two synchronizer flops. Steady levels and falling edges add nothing.
- R5: A tick at count 0xFFFF loads the preload value into the counter and sets the pending flag (address 3, bit 2). An overflow takes priority over a software clear in the same cycle.
- R6: A write to address 0 (low byte) or address 1 (high byte) updates the preload value. While the timer is stopped, the write also loads the new 16-bit preload into the counter. While it is running, the counter is not touched.
- R7: A read of address 0 returns the live low count byte and captures the high count byte. A read of address 1 returns the byte captured by the last low-byte read.
- R8: The pending flag stays set until software writes address 3 with bit 2 at 0. A write with bit 2 at 1 leaves the flag unchanged.
- R9: `irq_req` equals pending AND source enable (address 3, bit 1) AND master enable (address 3, bit 0 read back).
- R10: An `int_enter` pulse clears the master enable in the next cycle.
- R11: An `int_return` pulse sets the master enable in the next cycle, unless `int_enter` is high in the same cycle, in which case the master enable ends up cleared.
- R12: Writing address 3 sets bit 0 as the master enable and bit 1 as the source enable, below both strobes in priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (captures high byte on low-byte read) |
| bus_addr | input | 2 | Register address: 0 count low, 1 count high, 2 timer control, 3 interrupt control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_evt | input | 1 | Asynchronous external event input |
| int_enter | input | 1 | One-cycle strobe: CPU has taken an interrupt |
| int_return | input | 1 | One-cycle strobe: CPU executed return from interrupt |
| irq_req | output | 1 | Gated interrupt request |

## Verification
The counter is driven in three ways:
- free-running from a preload of zero, which separates counting from holding;
- from a preload just below all-ones, so that a wrap to a non-zero reload value shows whether the counter reloaded or fell back to zero;
- from external pulses and long steady levels, which separates edge counting from level counting.

A preload write made while the timer runs shows whether the counter was wrongly loaded. The interrupt path is tried with each of the three gate terms in turn, and with simultaneous entry and return strobes. Reading the high byte before and after a low-byte read tells a captured byte apart from a live one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ADDR_CNT_LO = 2'd0,
        ADDR_CNT_HI = 2'd1,
        ADDR_TCTL   = 2'd2,
        ADDR_ICTL   = 2'd3
    } tmr_reg_e;

    typedef enum logic {
        MODE_CLK = 1'b0,
        MODE_EXT = 1'b1
    } tmr_mode_e;

    typedef enum logic [1:0] {
        GATE_SHUT    = 2'd0,
        GATE_OPEN    = 2'd1,
        GATE_SERVICE = 2'd2
    } gate_state_e;

    localparam int TCTL_RUN_BIT  = 0;
    localparam int TCTL_MODE_BIT = 1;
    localparam int ICTL_ME_BIT   = 0;
    localparam int ICTL_SRC_BIT  = 1;
    localparam int ICTL_PEND_BIT = 2;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] stage_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            last_q  <= 1'b0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
            last_q  <= stage_q[STAGES-1];
        end
    end

    assign rise = stage_q[STAGES-1] && !last_q;

    // A single rising edge produces a one-cycle pulse
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    assign wrap = tick && !load && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (wrap) begin
            cnt_q <= reload_val;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt = cnt_q;

    // Without a tick or a load the count must not move
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic sw_we,
    input  logic sw_me,
    input  logic sw_src,
    input  logic sw_pend,
    input  logic int_enter,
    input  logic int_return,
    output logic master_en,
    output logic src_en,
    output logic pending,
    output logic irq_req
);

    gate_state_e state_q, state_d;
    logic        src_en_q;
    logic        pend_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: entry strobe, then return strobe, then software
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: begin
                if (int_enter) begin
                    state_d = GATE_SERVICE;
                end else if (int_return) begin
                    state_d = GATE_OPEN;
                end else if (sw_we && !sw_me) begin
                    state_d = GATE_SHUT;
                end
            end
            GATE_SERVICE: begin
                if (int_enter) begin
                    state_d = GATE_SERVICE;
                end else if (int_return || (sw_we && sw_me)) begin
                    state_d = GATE_OPEN;
                end
            end
            GATE_SHUT: begin
                if (int_enter) begin
                    state_d = GATE_SHUT;
                end else if (int_return || (sw_we && sw_me)) begin
                    state_d = GATE_OPEN;
                end
            end
            default: state_d = GATE_SHUT;
        endcase
    end

    // Output process
    always_comb begin
        master_en = 1'b0;
        unique case (state_q)
            GATE_OPEN:    master_en = 1'b1;
            GATE_SERVICE: master_en = 1'b0;
            GATE_SHUT:    master_en = 1'b0;
            default:      master_en = 1'b0;
        endcase
    end

    // Source enable and pending flag; overflow beats a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_en_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (sw_we) begin
                src_en_q <= sw_src;
            end
            if (wrap) begin
                pend_q <= 1'b1;
            end else if (sw_we && !sw_pend) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign src_en  = src_en_q;
    assign pending = pend_q;
    assign irq_req = pend_q && src_en_q && master_en;

    AST_PEND_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pending); // R5

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(sw_we && !sw_pend)) |=> pending); // R8

    AST_ME_DROP_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        int_enter |=> !master_en); // R10

    AST_ME_RISE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (int_return && !int_enter) |=> master_en); // R11

    AST_NO_REQ_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        int_enter |=> !irq_req); // R9

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_evt,
    input  logic              int_enter,
    input  logic              int_return,
    output logic              irq_req
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  preload_q, preload_d;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] hi_hold_q;
    logic              run_q;
    tmr_mode_e         mode_q;
    logic              wr_lo, wr_hi, wr_tctl, wr_ictl, rd_lo;
    logic              ext_rise, tick, load, wrap;
    logic              master_en, src_en, pending;

    assign wr_lo   = bus_wr && (bus_addr == ADDR_CNT_LO);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_CNT_HI);
    assign wr_tctl = bus_wr && (bus_addr == ADDR_TCTL);
    assign wr_ictl = bus_wr && (bus_addr == ADDR_ICTL);
    assign rd_lo   = bus_rd && (bus_addr == ADDR_CNT_LO);

    // Preload value as it will be after this cycle's write
    always_comb begin
        preload_d = preload_q;
        if (wr_lo) begin
            preload_d[DATA_W-1:0] = bus_wdata;
        end
        if (wr_hi) begin
            preload_d[CNT_W-1:DATA_W] = bus_wdata;
        end
    end

    assign load = (wr_lo || wr_hi) && !run_q;
    assign tick = run_q && ((mode_q == MODE_EXT) ? ext_rise : 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= '0;
            hi_hold_q <= '0;
            run_q     <= 1'b0;
            mode_q    <= MODE_CLK;
        end else begin
            preload_q <= preload_d;
            if (rd_lo) begin
                hi_hold_q <= cnt[CNT_W-1:DATA_W];
            end
            if (wr_tctl) begin
                run_q  <= bus_wdata[TCTL_RUN_BIT];
                mode_q <= tmr_mode_e'(bus_wdata[TCTL_MODE_BIT]);
            end
        end
    end

    tmr_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_evt),
        .rise  (ext_rise)
    );

    tmr_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load),
        .load_val   (preload_d),
        .reload_val (preload_q),
        .cnt        (cnt),
        .wrap       (wrap)
    );

    tmr_irq_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .sw_we      (wr_ictl),
        .sw_me      (bus_wdata[ICTL_ME_BIT]),
        .sw_src     (bus_wdata[ICTL_SRC_BIT]),
        .sw_pend    (bus_wdata[ICTL_PEND_BIT]),
        .int_enter  (int_enter),
        .int_return (int_return),
        .master_en  (master_en),
        .src_en     (src_en),
        .pending    (pending),
        .irq_req    (irq_req)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
            ADDR_CNT_HI: bus_rdata = hi_hold_q;
            ADDR_TCTL: begin
                bus_rdata[TCTL_RUN_BIT]  = run_q;
                bus_rdata[TCTL_MODE_BIT] = mode_q;
            end
            ADDR_ICTL: begin
                bus_rdata[ICTL_ME_BIT]   = master_en;
                bus_rdata[ICTL_SRC_BIT]  = src_en;
                bus_rdata[ICTL_PEND_BIT] = pending;
            end
            default: bus_rdata = '0;
        endcase
    end

    // A counter wrap only happens while the timer runs
    AST_WRAP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> run_q); // R5

    // A stopped timer never asserts a new overflow
    AST_STOP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !wrap); // R3

endmodule

// File: tb/tmr_irq_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_evt = 1'b0;
    logic       int_enter = 1'b0;
    logic       int_return = 1'b0;
    logic       irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Scoreboard: bit 8 selects irq (1) or read data (0)
    logic [8:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    always #2.5 clk = ~clk;

    tmr_irq_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_evt    (ext_evt),
        .int_enter  (int_enter),
        .int_return (int_return),
        .irq_req    (irq_req)
    );

    // Monitor
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                logic [8:0] it;
                string      tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                n_cmp++;
                if (it[8]) begin
                    if (irq_req !== it[0]) begin
                        n_bad++;
                        $display("FAIL %s irq_req actual=%0b expected=%0b", tg, irq_req, it[0]);
                    end
                end else begin
                    if (bus_rdata !== it[7:0]) begin
                        n_bad++;
                        $display("FAIL %s rdata actual=%02h expected=%02h", tg, bus_rdata, it[7:0]);
                    end
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'd0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tg);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        exp_q.push_back({1'b0, e});
        tag_q.push_back(tg);
        -> sample_ev;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tg);
        @(negedge clk);
        #1;
        exp_q.push_back({1'b1, 7'd0, e});
        tag_q.push_back(tg);
        -> sample_ev;
    endtask

    task automatic strobe(input logic ent, input logic ret);
        @(negedge clk);
        int_enter = ent; int_return = ret;
        @(negedge clk);
        int_enter = 1'b0; int_return = 1'b0;
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        rd_chk(2'd0, 8'h00, "R1 count low");
        rd_chk(2'd1, 8'h00, "R1 count high");
        rd_chk(2'd2, 8'h00, "R1 timer ctl");
        rd_chk(2'd3, 8'h00, "R1 irq ctl");
        irq_chk(1'b0, "R1 irq idle");

        // R2 clock mode: 10 idle cycles between start and stop give 12 ticks
        wr(2'd2, 8'h01);
        idle(10);
        wr(2'd2, 8'h00);
        rd_chk(2'd0, 8'h0C, "R2 clock count");
        // R3 stopped timer holds
        idle(5);
        rd_chk(2'd0, 8'h0C, "R3 hold while stopped");
        rd_chk(2'd1, 8'h00, "R3 high byte");

        // R6 stopped preload writes load counter; R7 readback
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h12);
        rd_chk(2'd0, 8'h34, "R6 loaded low");
        rd_chk(2'd1, 8'h12, "R7 captured high");

        // R5 overflow from FFF0: 22 ticks -> wrap to FFF0, then FFF6
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h03);
        irq_chk(1'b0, "R9 no pending yet");
        rd_chk(2'd3, 8'h03, "R12 enables written");
        wr(2'd2, 8'h01);
        idle(20);
        wr(2'd2, 8'h00);
        rd_chk(2'd0, 8'hF6, "R5 reload value used");
        rd_chk(2'd1, 8'hFF, "R5 high after reload");
        rd_chk(2'd3, 8'h07, "R5 pending set");
        irq_chk(1'b1, "R9 all gates true");

        // R10 entry clears master enable
        strobe(1'b1, 1'b0);
        irq_chk(1'b0, "R10 irq masked in service");
        rd_chk(2'd3, 8'h06, "R10 master enable off");
        // R11 return sets it again
        strobe(1'b0, 1'b1);
        rd_chk(2'd3, 8'h07, "R11 master enable back");
        irq_chk(1'b1, "R11 irq restored");

        // R8 write with bit2 set keeps pending
        wr(2'd3, 8'h07);
        rd_chk(2'd3, 8'h07, "R8 pending kept");
        // R9 source enable gates
        wr(2'd3, 8'h05);
        irq_chk(1'b0, "R9 source disabled");
        rd_chk(2'd3, 8'h05, "R9 regs src off");
        // R12 software clears master enable
        wr(2'd3, 8'h06);
        irq_chk(1'b0, "R12 master off by write");
        rd_chk(2'd3, 8'h06, "R12 readback");
        wr(2'd3, 8'h07);
        irq_chk(1'b1, "R12 master on by write");
        // R11 entry wins over simultaneous return
        strobe(1'b1, 1'b1);
        rd_chk(2'd3, 8'h06, "R11 entry beats return");
        strobe(1'b0, 1'b1);
        rd_chk(2'd3, 8'h07, "R11 return alone");
        // R8 clear
        wr(2'd3, 8'h03);
        rd_chk(2'd3, 8'h03, "R8 pending cleared");
        irq_chk(1'b0, "R8 irq gone");

        // R6 running preload write leaves counter alone: 4 ticks from FF00
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h00);
        rd_chk(2'd0, 8'h04, "R6 running write no load");
        rd_chk(2'd1, 8'hFF, "R6 high unchanged");

        // R4 external edges
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        rd_chk(2'd1, 8'hFF, "R7 high is captured copy");
        wr(2'd2, 8'h03);
        rd_chk(2'd2, 8'h03, "R4 mode readback");
        for (int i = 0; i < 3; i++) begin
            ext_evt = 1'b1;
            idle(4);
            ext_evt = 1'b0;
            idle(4);
        end
        ext_evt = 1'b1;
        idle(12);
        wr(2'd2, 8'h00);
        rd_chk(2'd0, 8'h04, "R4 edges counted");
        rd_chk(2'd1, 8'h00, "R7 high recaptured");

        idle(2);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog all-reqs actual=hung expected=finished");
        end
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule